// File: doc/BRIEF.md
# Prioritized Interrupt Request Recognizer

This block sits between seven active-low interrupt request lines and the sequencer of a CPU core. Each line passes through a stability filter that accepts a new value only once it has been seen unchanged on two consecutive rising clock edges. The block then takes the highest filtered level and compares it with the 3-bit priority mask from the status register. It drives a registered pending flag and the pending level. The sequencer samples these outputs between instructions or at the end of exception processing.

Levels one to six count only when they are strictly above the mask. Level seven cannot be masked. It is also edge-sensitive: a negated-to-asserted transition of the filtered line arms it, and the sequencer's acknowledge pulse disarms it. It is not recognised again until the line has been released and asserted once more. A source must hold its line until it is acknowledged. A line released earlier stops being pending.

Top module: `irq_level_recognizer`

## Requirements
- R1: `irq_n` is active low, and bit i carries request level i+1. With no qualifying request, `int_pending` is 0 and `int_level` is 0. When `int_pending` is 1, `int_level` is the nonzero level being reported.
- R2: A line's new value is accepted only when it is present on two consecutive rising edges. A request asserted for a single clock period never produces a pending output.
- R3: A request level that is steady from just before rising edge k appears on the outputs after edge k+2. A change of `mask` shows on the outputs after the next rising edge.
- R4: When several filtered lines are asserted, only the highest-numbered one is encoded and compared with the mask.
- R5: Levels 1 to 6 are pending only when the level is strictly greater than `mask`. A level equal to or below the mask gives `int_pending` = 0.
- R6: A negated-to-asserted transition of the filtered level-7 line makes level 7 pending for any mask value, including 7.
- R7: An `nmi_ack` pulse disarms level 7. While the line stays asserted, level 7 is then not pending again, and lower levels compete against the mask as usual. Releasing the line and asserting it again re-arms level 7.
- R8: A request whose line is released before acknowledge stops being pending. This applies to level 7 as well.
- R9: While `rst_n` is low, the filters, the level-7 edge state and the outputs are cleared, and the outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low request lines; bit i is level i+1 |
| mask | input | 3 | Priority mask from the status register |
| nmi_ack | input | 1 | One-cycle acknowledge that disarms level 7 |
| int_pending | output | 1 | A request above the mask (or an armed level 7) is pending |
| int_level | output | 3 | Pending level, 0 when nothing is pending |

## Verification
A change on the request lines takes three rising edges to reach the outputs: one to sample, one to accept, one to register. The bench therefore holds each stimulus for three clock periods and samples on the falling edge after the third. Mask changes and the level-7 acknowledge take effect one edge later than the event that causes them. The bench checks these exact cycles, and it also confirms that the outputs are still at their old value one edge before a result is due. A single-period glitch is watched on every falling edge for several cycles afterwards, because it must never reach the outputs.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
  localparam int NUM_LVL = 7;
  localparam int LVL_W   = $clog2(NUM_LVL + 1);
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NUM_LVL);

  // Highest set bit of a request vector, as a level number (bit i -> level i+1)
  function automatic logic [LVL_W-1:0] highest_level(input logic [NUM_LVL-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (v[i]) r = LVL_W'(i + 1);
    return r;
  endfunction

  // Nonmaskable top level, otherwise strictly above the mask
  function automatic logic beats_mask(input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] msk);
    return (lvl == NMI_LVL) || (lvl > msk);
  endfunction
endpackage

// File: rtl/irq_line_filter.sv
module irq_line_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic req_raw,
  output logic req_stable
);
  logic smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q      <= 1'b0;
      req_stable <= 1'b0;
    end else begin
      smp_q <= req_raw;
      if (req_raw == smp_q) req_stable <= req_raw;
    end
  end
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stable,
  input  logic ack,
  output logic rise,
  output logic armed,
  output logic nmi_req
);
  logic prev_q;

  assign rise    = line_stable & ~prev_q;
  assign nmi_req = line_stable & (armed | rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      prev_q <= line_stable;
      if (rise)     armed <= 1'b1;
      else if (ack) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_priority_sel.sv
module irq_priority_sel
  import irq_rec_pkg::*;
(
  input  logic [NUM_LVL-1:0] req_vec,
  input  logic [LVL_W-1:0]   mask,
  output logic               sel_pending,
  output logic [LVL_W-1:0]   sel_level
);
  logic [LVL_W-1:0] top_lvl;

  always_comb begin
    top_lvl     = highest_level(req_vec);
    sel_pending = beats_mask(top_lvl, mask);
    sel_level   = sel_pending ? top_lvl : '0;
  end
endmodule

// File: rtl/irq_level_recognizer.sv
module irq_level_recognizer
  import irq_rec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_n,
  input  logic [LVL_W-1:0]   mask,
  input  logic               nmi_ack,
  output logic               int_pending,
  output logic [LVL_W-1:0]   int_level
);
  logic [NUM_LVL-1:0] filt_lvl;
  logic [NUM_LVL-1:0] req_vec;
  logic               nmi_rise;
  logic               nmi_armed;
  logic               nmi_req;
  logic               sel_pending;
  logic [LVL_W-1:0]   sel_level;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_filt
    irq_line_filter u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_raw    (~irq_n[g]),
      .req_stable (filt_lvl[g])
    );
  end

  irq_nmi_edge u_nmi (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_stable (filt_lvl[NUM_LVL-1]),
    .ack         (nmi_ack),
    .rise        (nmi_rise),
    .armed       (nmi_armed),
    .nmi_req     (nmi_req)
  );

  assign req_vec = {nmi_req, filt_lvl[NUM_LVL-2:0]};

  irq_priority_sel u_sel (
    .req_vec     (req_vec),
    .mask        (mask),
    .sel_pending (sel_pending),
    .sel_level   (sel_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_pending <= 1'b0;
      int_level   <= '0;
    end else begin
      int_pending <= sel_pending;
      int_level   <= sel_level;
    end
  end
endmodule

// File: rtl/irq_recognizer_chk.sv
module irq_recognizer_chk
  import irq_rec_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_LVL-1:0] irq_n,
  input logic [LVL_W-1:0]   mask,
  input logic               nmi_ack,
  input logic               int_pending,
  input logic [LVL_W-1:0]   int_level,
  input logic [NUM_LVL-1:0] filt_lvl,
  input logic               nmi_rise,
  input logic               nmi_armed
);
  // R1
  idle_level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_pending |-> int_level == '0);

  // R1
  pending_level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pending |-> int_level != '0);

  // R5
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pending && int_level != NMI_LVL) |-> int_level > $past(mask));

  // R6
  nmi_edge_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> (int_pending && int_level == NMI_LVL));

  // R7
  ack_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !nmi_rise) |=> !nmi_armed);

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_flt_chk
    // R2
    filter_two_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_lvl[g] != $past(filt_lvl[g])) |->
        (filt_lvl[g] == !$past(irq_n[g]) && $past(irq_n[g]) == $past(irq_n[g], 2)));
  end
endmodule

bind irq_level_recognizer irq_recognizer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_n       (irq_n),
  .mask        (mask),
  .nmi_ack     (nmi_ack),
  .int_pending (int_pending),
  .int_level   (int_level),
  .filt_lvl    (filt_lvl),
  .nmi_rise    (nmi_rise),
  .nmi_armed   (nmi_armed)
);

// File: tb/test_irq_level_recognizer.sv
module test_irq_level_recognizer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // {irq_n[6:0], mask[2:0], exp_pending, exp_level[2:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {7'h7F, 3'd0, 1'b0, 3'd0},
    {7'h7E, 3'd0, 1'b1, 3'd1},
    {7'h7E, 3'd1, 1'b0, 3'd0},
    {7'h6B, 3'd4, 1'b1, 3'd5},
    {7'h6B, 3'd5, 1'b0, 3'd0},
    {7'h5F, 3'd5, 1'b1, 3'd6},
    {7'h5F, 3'd6, 1'b0, 3'd0},
    {7'h5D, 3'd7, 1'b0, 3'd0},
    {7'h7D, 3'd1, 1'b1, 3'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] irq_n;
  logic [2:0] mask;
  logic       nmi_ack;
  logic       int_pending;
  logic [2:0] int_level;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_recognizer i_irq_level_recognizer (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_n       (irq_n),
    .mask        (mask),
    .nmi_ack     (nmi_ack),
    .int_pending (int_pending),
    .int_level   (int_level)
  );

  task automatic check(input string req, input logic exp_p, input logic [2:0] exp_l);
    total++;
    if (int_pending !== exp_p || int_level !== exp_l) begin
      bad++;
      $display("FAIL %s: actual pending=%0b level=%0d expected pending=%0b level=%0d",
               req, int_pending, int_level, exp_p, exp_l);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_n = 7'h7F; mask = 3'd0; nmi_ack = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset state", 1'b0, 3'd0);
    rst_n = 1'b1;
    settle();
    check("R1 idle after reset", 1'b0, 3'd0);

    // Vector table: R1, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      irq_n = VEC[i][13:7];
      mask  = VEC[i][6:4];
      settle();
      check($sformatf("R4/R5 vector %0d", i), VEC[i][3], VEC[i][2:0]);
    end

    // R3 latency of a request, then of a mask change
    irq_n = 7'h7F; mask = 3'd0; settle();
    irq_n = 7'h7B;
    repeat (2) @(negedge clk);
    check("R3 not yet after two edges", 1'b0, 3'd0);
    @(negedge clk);
    check("R3 due after third edge", 1'b1, 3'd3);
    mask = 3'd3;
    @(negedge clk);
    check("R3 mask change next edge", 1'b0, 3'd0);

    // R2 single-period glitch
    irq_n = 7'h7F; mask = 3'd0; settle();
    irq_n = 7'h77;
    @(negedge clk);
    irq_n = 7'h7F;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R2 glitch filtered", 1'b0, 3'd0);
    end

    // R6 level 7 ignores a full mask
    mask = 3'd7; irq_n = 7'h3F; settle();
    check("R6 level 7 with mask 7", 1'b1, 3'd7);
    // R7 acknowledge disarms
    nmi_ack = 1'b1;
    @(negedge clk);
    nmi_ack = 1'b0;
    @(negedge clk);
    check("R7 cleared after ack", 1'b0, 3'd0);
    settle();
    check("R7 held line not re-recognised", 1'b0, 3'd0);
    irq_n = 7'h3B; mask = 3'd2; settle();
    check("R7 lower level competes while disarmed", 1'b1, 3'd3);
    irq_n = 7'h7B; settle();
    check("R7 level 7 released", 1'b1, 3'd3);
    irq_n = 7'h3B; settle();
    check("R7 re-armed on new transition", 1'b1, 3'd7);

    // R8 release before acknowledge
    irq_n = 7'h7B; settle();
    check("R8 level 7 released unacknowledged", 1'b1, 3'd3);
    irq_n = 7'h7F; settle();
    check("R8 level 3 released", 1'b0, 3'd0);

    // R9 reset in the middle of a request
    irq_n = 7'h5F; mask = 3'd0; settle();
    check("R9 pre-reset pending", 1'b1, 3'd6);
    rst_n = 1'b0;
    #1;
    check("R9 reset clears outputs", 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R9 request seen again after reset", 1'b1, 3'd6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule